// File: doc/BRIEF.md
# GPIO Port Controller with Input Filtering and Interrupt Triggers

This block holds the registers and pin logic for one general-purpose I/O port of up to eight pins. Software reaches it over a simple single-cycle register bus. Each pin owns a 32-byte register window. The window holds the pin's configuration, a debounce threshold, the filtered input level, a tri-state control, the output value and an interrupt clear strobe. One extra word, at byte offset 0x100, gathers the latched interrupt status of every pin, so a handler can find the source by scanning its set bits.

Every pad input passes through a two-flop synchroniser. It then goes through an optional debounce filter, which counts millisecond ticks supplied by the system. The filtered level feeds the input register and a trigger detector. The detector latches a sticky status bit on a level, on one chosen edge or on both edges. A separate polarity bit picks high/rising or low/falling for the level and single-edge modes. The port raises its single interrupt line whenever a pin is enabled, has its interrupt enable set and has its status latched.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every pin configuration word reads 0, every tri-state bit reads 1, the output value and debounce threshold read 0, the status word reads 0, and `pad_oe` and `irq` are low.
- R2: The configuration word at pin offset 0x00 stores 8 bits and reads them back unchanged. Its fields are: bit 0 pin enable, bit 1 output direction, bits [3:2] trigger kind (0 off, 1 level, 2 single edge, 3 both edges), bit 4 polarity, bit 5 debounce enable, bit 6 interrupt enable, bit 7 timestamp enable (stored only).
- R3: `pad_oe[i]` is high exactly when pin i has enable (bit 0) and output direction (bit 1) set and its tri-state bit (offset 0x0C, bit 0) is 0. `pad_out[i]` follows the output value bit (offset 0x10, bit 0).
- R4: The input register (offset 0x08, bit 0) shows the pad level three clock edges after it changes when the filter is bypassed: two synchroniser stages plus the filter register.
- R5: With debounce enabled and a threshold T > 0 (offset 0x04, bits [7:0]), the input register takes a new level only after the synchronised pad has differed from it for T consecutive `ms_tick` pulses. A pulse that returns before then leaves it unchanged.
- R6: With debounce disabled, or with a threshold of 0, the filter is bypassed as in R4.
- R7: Single-edge mode latches status on a rising edge when polarity is 1 and on a falling edge when polarity is 0. The opposite edge latches nothing.
- R8: Both-edges mode latches status on either edge, whatever the polarity.
- R9: Level mode latches status while the level equals the polarity bit. A clear written while that level persists leaves the status set.
- R10: Writing bit 0 = 1 to offset 0x14 clears the pin's latched status. Writing 0 there has no effect, and status otherwise stays set until cleared.
- R11: The word at offset 0x100 holds pin i's status in bit i. `irq` is high exactly when some pin has status, enable and interrupt enable all set.
- R12: A pin with enable clear, or with trigger kind 0, never latches status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond, advances debounce counters |
| reg_sel | input | 1 | Register access valid |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address: [7:5] pin, [4:2] register, [8] status word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from the address |
| pad_in | input | PINS | Raw pad input levels |
| pad_out | output | PINS | Pad output values |
| pad_oe | output | PINS | Pad output enables (0 = tri-stated) |
| irq | output | 1 | Port interrupt to the upstream controller |

## Verification
The bench aims at four corners: the clear that lands while a level trigger still holds, the opposite edge in single-edge mode, a short debounce glitch that returns before its threshold, and a threshold of zero with the filter enabled. A design that gave the clear priority would show the level status dropping for a moment. One that ignored polarity would latch on the wrong edge. A filter that did not restart its count would pass the glitch, and one that treated zero as 256 would freeze the input register. Random configuration writes also check the drive enable against the tri-state and direction bits on all pins at once.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF        = 2'd0,
    TRIG_LEVEL      = 2'd1,
    TRIG_ONE_EDGE   = 2'd2,
    TRIG_BOTH_EDGES = 2'd3
  } trig_kind_e;

  // Packed MSB first: bit 7 stamp ... bit 0 enable
  typedef struct packed {
    logic       stamp;
    logic       irq_en;
    logic       filt_en;
    logic       polarity;
    trig_kind_e kind;
    logic       drive_out;
    logic       enable;
  } pin_cfg_t;

  // Register index within a pin window (byte offset / 4)
  localparam logic [2:0] RI_CFG   = 3'd0;
  localparam logic [2:0] RI_THR   = 3'd1;
  localparam logic [2:0] RI_LEVEL = 3'd2;
  localparam logic [2:0] RI_FLOAT = 3'd3;
  localparam logic [2:0] RI_OUTV  = 3'd4;
  localparam logic [2:0] RI_CLEAR = 3'd5;

endpackage

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pad_i,
  input  logic             tick_i,
  input  logic             filt_en_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             level_o
);
  localparam logic [THR_W-1:0] ONE = THR_W'(1);

  logic [1:0]       sync_q;
  logic             raw;
  logic             active;
  logic [THR_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;

  assign raw     = sync_q[1];
  assign active  = filt_en_i && (thr_i != '0);
  assign level_o = lvl_q;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (!active) begin
      cnt_d = '0;
      lvl_d = raw;
    end else if (raw == lvl_q) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q >= thr_i - ONE) begin
        cnt_d = '0;
        lvl_d = raw;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pad_i};
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
    end
  end

  // R5: an active filter only moves its output on a tick
  p_hold_without_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick_i) |=> $stable(level_o));

  // R6: a bypassed filter copies the synchronised level one edge later
  p_bypass_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (level_o == $past(raw)));

endmodule

// File: rtl/gpio_pin_event.sv
module gpio_pin_event
  import gpio_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level_i,
  input  logic       enable_i,
  input  trig_kind_e kind_i,
  input  logic       polarity_i,
  input  logic       clear_i,
  output logic       status_o
);
  logic prev_q;
  logic status_q, status_d;
  logic rise, fall, cond, hit;

  assign status_o = status_q;

  always_comb begin
    rise = level_i & ~prev_q;
    fall = ~level_i & prev_q;
    case (kind_i)
      TRIG_LEVEL:      cond = (level_i == polarity_i);
      TRIG_ONE_EDGE:   cond = polarity_i ? rise : fall;
      TRIG_BOTH_EDGES: cond = rise | fall;
      default:         cond = 1'b0;
    endcase
    hit      = enable_i & cond;
    status_d = hit | (status_q & ~clear_i);   // a new hit outranks a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      prev_q   <= level_i;
      status_q <= status_d;
    end
  end

  // R10: status is sticky until a clear strobe
  p_sticky_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !clear_i) |=> status_q);

  // R12: a disabled or untriggered pin cannot latch
  p_no_latch_when_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((!enable_i || kind_i == TRIG_OFF) && !status_q) |=> !status_q);

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int THR_W  = 8,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              irq
);
  localparam int WIN_LSB   = 5;            // 32-byte window per pin
  localparam int IDX_W     = 3;            // up to eight windows
  localparam int STAT_BIT  = WIN_LSB + IDX_W;
  localparam logic [IDX_W:0] PIN_LIMIT = (IDX_W+1)'(PINS);

  logic [IDX_W-1:0] pin_idx;
  logic [2:0]       reg_idx;
  logic             stat_hit, wr_go;

  pin_cfg_t         cfg_q [PINS];
  pin_cfg_t         cfg_d [PINS];
  logic [THR_W-1:0] thr_q [PINS];
  logic [THR_W-1:0] thr_d [PINS];
  logic [PINS-1:0]  float_q, float_d, outv_q, outv_d, clr;
  logic [PINS-1:0]  level, status, armed;

  assign pin_idx  = reg_addr[WIN_LSB +: IDX_W];
  assign reg_idx  = reg_addr[4:2];
  assign stat_hit = reg_addr[STAT_BIT];
  assign wr_go    = reg_sel && reg_wr && !stat_hit && ({1'b0, pin_idx} < PIN_LIMIT);

  // next state of the per-pin registers
  always_comb begin
    for (int i = 0; i < PINS; i++) begin
      cfg_d[i]   = cfg_q[i];
      thr_d[i]   = thr_q[i];
      float_d[i] = float_q[i];
      outv_d[i]  = outv_q[i];
      clr[i]     = 1'b0;
      if (wr_go && pin_idx == IDX_W'(i)) begin
        case (reg_idx)
          RI_CFG:   cfg_d[i]   = pin_cfg_t'(reg_wdata[7:0]);
          RI_THR:   thr_d[i]   = reg_wdata[THR_W-1:0];
          RI_FLOAT: float_d[i] = reg_wdata[0];
          RI_OUTV:  outv_d[i]  = reg_wdata[0];
          RI_CLEAR: clr[i]     = reg_wdata[0];
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PINS; i++) begin
        cfg_q[i] <= '0;
        thr_q[i] <= '0;
      end
      float_q <= '1;
      outv_q  <= '0;
    end else begin
      for (int i = 0; i < PINS; i++) begin
        cfg_q[i] <= cfg_d[i];
        thr_q[i] <= thr_d[i];
      end
      float_q <= float_d;
      outv_q  <= outv_d;
    end
  end

  // read path
  always_comb begin
    reg_rdata = '0;
    if (stat_hit) begin
      reg_rdata[PINS-1:0] = status;
    end else if ({1'b0, pin_idx} < PIN_LIMIT) begin
      case (reg_idx)
        RI_CFG:   reg_rdata[7:0]       = cfg_q[pin_idx];
        RI_THR:   reg_rdata[THR_W-1:0] = thr_q[pin_idx];
        RI_LEVEL: reg_rdata[0]         = level[pin_idx];
        RI_FLOAT: reg_rdata[0]         = float_q[pin_idx];
        RI_OUTV:  reg_rdata[0]         = outv_q[pin_idx];
        default:  ;
      endcase
    end
  end

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    gpio_pin_filter #(.THR_W(THR_W)) u_filter (
      .clk       (clk),
      .rst_n     (rst_n),
      .pad_i     (pad_in[g]),
      .tick_i    (ms_tick),
      .filt_en_i (cfg_q[g].filt_en),
      .thr_i     (thr_q[g]),
      .level_o   (level[g])
    );

    gpio_pin_event u_event (
      .clk        (clk),
      .rst_n      (rst_n),
      .level_i    (level[g]),
      .enable_i   (cfg_q[g].enable),
      .kind_i     (cfg_q[g].kind),
      .polarity_i (cfg_q[g].polarity),
      .clear_i    (clr[g]),
      .status_o   (status[g])
    );

    assign pad_oe[g] = cfg_q[g].enable & cfg_q[g].drive_out & ~float_q[g];
    assign armed[g]  = cfg_q[g].enable & cfg_q[g].irq_en;
  end

  assign pad_out = outv_q;
  assign irq     = |(status & armed);

  // R11: the upstream line never rises without a latched pin
  p_irq_needs_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));

endmodule

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;
  localparam int PINS = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ms_tick;
  logic        reg_sel, reg_wr;
  logic [8:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [PINS-1:0] pad_in, pad_out, pad_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0]      m_cfg [PINS];
  logic [PINS-1:0] m_float, m_outv;

  always #2.5 clk = ~clk;   // 200 MHz

  gpio_port_ctrl u_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic [8:0] ra(int pin, int idx);
    return 9'(pin * 32 + idx * 4);
  endfunction

  function automatic logic [PINS-1:0] exp_oe();
    logic [PINS-1:0] v;
    for (int i = 0; i < PINS; i++) v[i] = m_cfg[i][0] & m_cfg[i][1] & ~m_float[i];
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
    idle(2);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(3); rst_n = 1'b1;
    for (int i = 0; i < PINS; i++) m_cfg[i] = 8'h00;
    m_float = '1; m_outv = '0;
    idle(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    reg_sel = 0; reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    ms_tick = 0; pad_in = '0; rst_n = 1'b0;
    void'($urandom(32'h1234_5eed));
    do_reset();

    // R1 reset state
    for (int p = 0; p < PINS; p++) begin
      rd(ra(p, 0), d); chk("R1 cfg", d, 0);
      rd(ra(p, 3), d); chk("R1 float", d, 1);
      rd(ra(p, 1), d); chk("R1 thr", d, 0);
      rd(ra(p, 4), d); chk("R1 outv", d, 0);
    end
    rd(9'h100, d); chk("R1 status", d, 0);
    chk("R1 oe", 32'(pad_oe), 0);
    chk("R1 irq", 32'(irq), 0);

    // R2/R3/R4 random configuration, drive and input sampling
    for (int n = 0; n < 60; n++) begin
      int p = $urandom_range(0, PINS - 1);
      int k = $urandom_range(0, 2);
      logic [31:0] v = $urandom;
      v[5] = 1'b0;   // keep the filter off in this phase
      if (k == 0) begin
        wr(ra(p, 0), v); m_cfg[p] = v[7:0];
        rd(ra(p, 0), d); chk("R2 cfg readback", d, 32'(v[7:0]));
      end else if (k == 1) begin
        wr(ra(p, 3), v); m_float[p] = v[0];
        rd(ra(p, 3), d); chk("R3 float readback", d, 32'(v[0]));
      end else begin
        wr(ra(p, 4), v); m_outv[p] = v[0];
      end
      idle(1);
      chk("R3 pad_oe", 32'(pad_oe), 32'(exp_oe()));
      chk("R3 pad_out", 32'(pad_out), 32'(m_outv));
      pad_in = PINS'($urandom);
      idle(2);
      rd(ra(p, 2), d);   // three edges after the change
      chk("R4 input level", d, 32'(pad_in[p]));
    end

    do_reset();
    pad_in = '0; idle(5);

    // R7 single edge, rising (cfg 0x19)
    wr(ra(2, 0), 32'h19);
    pad_in[2] = 1; idle(6);
    rd(9'h100, d); chk("R7 rising latched", d, 32'h04);
    chk("R11 irq masked", 32'(irq), 0);
    wr(ra(2, 0), 32'h59); idle(1);
    chk("R11 irq armed", 32'(irq), 1);
    wr(ra(2, 5), 32'h0); idle(2);
    rd(9'h100, d); chk("R10 clear of 0 ignored", d, 32'h04);
    wr(ra(2, 5), 32'h1); idle(2);
    rd(9'h100, d); chk("R10 cleared", d, 0);
    chk("R11 irq dropped", 32'(irq), 0);
    pad_in[2] = 0; idle(6);
    rd(9'h100, d); chk("R7 falling ignored when rising", d, 0);
    // R7 falling (cfg 0x09)
    wr(ra(2, 0), 32'h09);
    pad_in[2] = 1; idle(6);
    rd(9'h100, d); chk("R7 rising ignored when falling", d, 0);
    pad_in[2] = 0; idle(6);
    rd(9'h100, d); chk("R7 falling latched", d, 32'h04);
    wr(ra(2, 5), 32'h1);

    // R8 both edges, polarity 0 and 1 (cfg 0x0D / 0x1D)
    wr(ra(6, 0), 32'h0D);
    pad_in[6] = 1; idle(6);
    rd(9'h100, d); chk("R8 rise latched", d, 32'h40);
    wr(ra(6, 5), 32'h1);
    wr(ra(6, 0), 32'h1D);
    pad_in[6] = 0; idle(6);
    rd(9'h100, d); chk("R8 fall latched", d, 32'h40);
    wr(ra(6, 5), 32'h1); idle(2);

    // R9 level high (cfg 0x15) and re-latch after clear
    wr(ra(1, 0), 32'h15);
    pad_in[1] = 1; idle(6);
    rd(9'h100, d); chk("R9 level high latched", d, 32'h02);
    wr(ra(1, 5), 32'h1); idle(2);
    rd(9'h100, d); chk("R9 re-latch while level held", d, 32'h02);
    pad_in[1] = 0; idle(6);
    wr(ra(1, 5), 32'h1); idle(2);
    rd(9'h100, d); chk("R9 released after level gone", d, 0);
    wr(ra(1, 0), 32'h05); idle(2);
    rd(9'h100, d); chk("R9 level low latched", d, 32'h02);
    wr(ra(1, 0), 32'h00);
    wr(ra(1, 5), 32'h1);

    // R12 disabled pin and trigger kind off
    wr(ra(3, 0), 32'h18);
    wr(ra(4, 0), 32'h11);
    pad_in[3] = 1; pad_in[4] = 1; idle(6);
    rd(9'h100, d); chk("R12 no latch disabled/off", d, 0);

    // R5 debounce threshold 3 on pin 5 (cfg 0x21)
    wr(ra(5, 1), 32'd3);
    wr(ra(5, 0), 32'h21);
    idle(4);
    rd(ra(5, 2), d); chk("R5 start low", d, 0);
    pad_in[5] = 1; idle(4);
    rd(ra(5, 2), d); chk("R5 no change without ticks", d, 0);
    tick(); tick();
    rd(ra(5, 2), d); chk("R5 two ticks not enough", d, 0);
    pad_in[5] = 0; idle(4);
    tick();
    pad_in[5] = 1; idle(4);
    tick(); tick();
    rd(ra(5, 2), d); chk("R5 glitch restarted count", d, 0);
    tick();
    rd(ra(5, 2), d); chk("R5 accepted after threshold", d, 1);

    // R6 threshold 0 with filter enabled, then filter disabled
    wr(ra(5, 1), 32'd0);
    pad_in[5] = 0; idle(2);
    rd(ra(5, 2), d); chk("R6 zero threshold bypass", d, 0);
    wr(ra(5, 1), 32'd9);
    wr(ra(5, 0), 32'h01);
    pad_in[5] = 1; idle(2);
    rd(ra(5, 2), d); chk("R6 disabled filter bypass", d, 1);

    finish_run();
  end
endmodule